// File: doc/BRIEF.md
# Linked Descriptor Queue Controller

This block runs a work list that software builds in system memory as a physically linked chain of command descriptors. Software writes the byte address of a shared master control block into a start register. The controller reads the master block's control word and the address of the first descriptor. It then walks the chain over a word-wide memory master port that uses a request/grant handshake. In queued mode every fetched descriptor goes into an internal queue sorted by priority. In immediate mode only the first descriptor runs.

No disk media is attached. Each command "executes" for a programmable number of cycles and finishes with an error result taken from an input. When a command completes, the controller writes three fields into the master block: the descriptor's context word, the descriptor's own address, and a status word. It can then raise a one-cycle interrupt. A second register asks the controller to store an identity word at a given address. Two more registers stop the controller: one in an orderly way, one at once.

FSM states and transitions:

| State | Action | Leaves to |
|---|---|---|
| S_IDLE | no bus activity | S_RD_CTL on a start write; S_ID_WR if an identity request is pending |
| S_RD_CTL | read control word (master +0) | S_CLR_STS if bit 4 or bit 0 is set, else S_IDLE |
| S_CLR_STS | write 0 to status (master +20) | S_RD_HEAD |
| S_RD_HEAD | read first-descriptor address (master +8) | S_RD_LINK if non-zero, else S_IDLE |
| S_RD_LINK | read descriptor link (+0) | S_RD_CW1 |
| S_RD_CW1 | read control word 1 (+4), insert into queue | S_SCHED |
| S_SCHED | pick next action | S_ID_WR, S_RD_LINK (queued, more chain, room), S_EXEC (queue not empty), S_RECHECK (queued, empty), S_IDLE |
| S_RECHECK | re-read link of last fetched descriptor | S_SCHED if non-zero, else S_IDLE |
| S_EXEC | latency countdown | S_RD_CTX on expiry |
| S_RD_CTX | read descriptor context (+20) | S_WB_CTX |
| S_WB_CTX | write context to master +28 | S_WB_CADDR |
| S_WB_CADDR | write descriptor address to master +24 | S_WB_STS |
| S_WB_STS | write status to master +20 | S_SCHED |
| S_ID_WR | write identity word | S_SCHED or S_IDLE, whichever it came from |

A pending orderly stop sends any state to S_IDLE. From a bus state this happens only once the current transfer is granted. A hard stop sends any state to S_IDLE at the next edge.

Top module: `desc_queue_ctrl`

## Requirements
- R1: After reset, mem_req and irq are low and the controller accepts a start write.
- R2: Register word index 0 is the start register, 1 the identity request, 2 the orderly stop and 3 the hard stop. A start write reads the control word at master +0. If control bit 4 or bit 0 is set, the controller then writes 0 to the status word at master +20 and reads the first-descriptor address at master +8. If neither bit is set, it returns to idle and writes nothing.
- R3: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until the cycle in which mem_gnt is high. That cycle completes the transfer, and read data is taken in it.
- R4: Descriptor layout: +0 is the next-descriptor address, and a zero address ends the chain. +4 is control word 1 with priority in [31:24], interrupt request in [23], drive in [22:16] and command in [15:0]. +20 is the context word.
- R5: With control bit 4 set (queued), the fetched descriptors run in order of numerically higher priority first. Descriptors with equal priority run in the order they were fetched.
- R6: With bit 4 clear and bit 0 set (immediate), only the first descriptor runs. Its link is not followed.
- R7: Each command runs for cmd_lat+1 cycles. Then the controller writes the descriptor's context word to master +28, the descriptor's address to master +24, and the status to master +20. The status has bit 7 (done) set, with bit 1 = cmd_err[1] (fatal) and bit 0 = cmd_err[0] (recoverable).
- R8: irq is high for exactly one cycle, in the cycle after the status write is granted. It rises only when the completed descriptor's interrupt bit is set.
- R9: The queue holds at most 32 descriptors. Further chain entries are fetched only as slots free up, so a high-priority descriptor beyond the 32nd runs only after a queued one completes.
- R10: In queued mode, when the queue drains, the link of the last fetched descriptor is read again. A non-zero value there continues the walk.
- R11: An identity request writes one word to the written address. Bits [7:0] = 0x01 (module id), [15:8] = 0x00, [23:16] = the microcode revision (default 0x12), [31:24] = 0xFF (self-test passed). The request is served when idle or between descriptors.
- R12: An orderly stop lets the memory transfer in progress finish, then returns to idle with the queue emptied. No further transfers are started.
- R13: A hard stop drops mem_req at the next edge, even if the transfer has not been granted, and returns to idle.
- R14: A start write while the controller is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; completes the transfer |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| cmd_lat | input | 16 | Command execution latency in cycles |
| cmd_err | input | 2 | Error result of a command {fatal, recoverable} |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Queued chains are run with mixed priorities and mixed interrupt bits. This separates sorting by priority from fetch order and shows that the interrupt is gated per descriptor. An immediate-mode chain, a 33-entry chain whose last entry has the highest priority, and a chain extended while running show whether the controller follows links, respects the queue bound and re-reads the tail. Orderly and hard stops are issued while a grant is held back. This tells a stop that waits for the transfer apart from one that abandons it. Error codes and the identity word check the bit positions that the status and identity words carry.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int DQ_AW = 32;
    localparam int DQ_DW = 32;

    // master block byte offsets
    localparam logic [DQ_AW-1:0] MB_CTL   = 32'd0;
    localparam logic [DQ_AW-1:0] MB_HEAD  = 32'd8;
    localparam logic [DQ_AW-1:0] MB_STS   = 32'd20;
    localparam logic [DQ_AW-1:0] MB_CADDR = 32'd24;
    localparam logic [DQ_AW-1:0] MB_CTX   = 32'd28;

    // descriptor byte offsets
    localparam logic [DQ_AW-1:0] DS_NEXT = 32'd0;
    localparam logic [DQ_AW-1:0] DS_CW1  = 32'd4;
    localparam logic [DQ_AW-1:0] DS_CTX  = 32'd20;

    localparam int CTL_QUEUED = 4;
    localparam int CTL_IMMED  = 0;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_CTL, S_CLR_STS, S_RD_HEAD, S_RD_LINK, S_RD_CW1,
        S_SCHED, S_RECHECK, S_EXEC, S_RD_CTX, S_WB_CTX, S_WB_CADDR,
        S_WB_STS, S_ID_WR
    } dq_state_t;

    typedef struct packed {
        logic [DQ_AW-1:0] addr;
        logic [7:0]       prio;
        logic             intr;
    } qent_t;
endpackage

// File: rtl/dq_reg_dec.sv
module dq_reg_dec (
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    output logic       start_p,
    output logic       id_p,
    output logic       soft_p,
    output logic       hard_p
);
    always_comb begin
        start_p = 1'b0;
        id_p    = 1'b0;
        soft_p  = 1'b0;
        hard_p  = 1'b0;
        if (reg_wr) begin
            unique case (reg_addr)
                2'd0: start_p = 1'b1;
                2'd1: id_p    = 1'b1;
                2'd2: soft_p  = 1'b1;
                2'd3: hard_p  = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dq_prio_queue.sv
module dq_prio_queue
    import dq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  ins,
    input  qent_t ins_ent,
    input  logic  pop,
    output qent_t head,
    output logic  full,
    output logic  empty
);
    localparam int CW = $clog2(DEPTH + 1);

    qent_t          q  [DEPTH];
    qent_t          lo [DEPTH];
    qent_t          hi [DEPTH];
    logic [CW-1:0]  count;
    logic [CW-1:0]  pos;

    // neighbour taps for shifting down on insert and up on pop
    for (genvar g = 0; g < DEPTH; g++) begin : g_nbr
        if (g == 0) begin : g_first
            assign lo[g] = ins_ent;
        end else begin : g_rest
            assign lo[g] = q[g-1];
        end
        if (g == DEPTH - 1) begin : g_last
            assign hi[g] = '0;
        end else begin : g_mid
            assign hi[g] = q[g+1];
        end
    end

    // new entry goes behind every valid entry of equal or higher priority
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < count && q[i].prio >= ins_ent.prio)
                pos = pos + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else if (flush) begin
            count <= '0;
        end else if (ins) begin
            count <= count + CW'(1);
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == pos)     q[i] <= ins_ent;
                else if (CW'(i) > pos) q[i] <= lo[i];
            end
        end else if (pop && count != '0) begin
            count <= count - CW'(1);
            for (int i = 0; i < DEPTH; i++) q[i] <= hi[i];
        end
    end

    assign head  = q[0];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !flush) |-> !full);
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r5_head_sorted: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= CW'(2)) |-> (q[0].prio >= q[1].prio));
endmodule

// File: rtl/dq_lat_timer.sv
module dq_lat_timer #(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] lat,
    input  logic             run,
    output logic             done
);
    logic [LAT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= lat;
        else if (run && cnt != '0)  cnt <= cnt - LAT_W'(1);
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/desc_queue_ctrl.sv
module desc_queue_ctrl
    import dq_pkg::*;
#(
    parameter int         QDEPTH   = 32,
    parameter int         LAT_W    = 16,
    parameter logic [7:0] CODE_REV = 8'h12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    input  logic [LAT_W-1:0] cmd_lat,
    input  logic [1:0]       cmd_err,
    output logic             irq
);
    localparam logic [DQ_DW-1:0] ID_WORD = {8'hFF, CODE_REV, 8'h00, 8'h01};

    dq_state_t        state, state_n;
    logic             start_p, id_p, soft_p, hard_p;
    logic             xfer;
    logic [DQ_AW-1:0] mb, cur, nxt, tail, id_addr;
    logic [DQ_DW-1:0] ctx;
    logic [1:0]       err_q;
    logic             imm, id_pend, id_ret, stop_pend, irq_q;
    qent_t            exec_ent, q_head, ins_ent;
    logic             q_full, q_empty, q_ins, q_pop, q_flush;
    logic             t_done;

    dq_reg_dec u_dec (
        .reg_wr  (reg_wr),
        .reg_addr(reg_addr),
        .start_p (start_p),
        .id_p    (id_p),
        .soft_p  (soft_p),
        .hard_p  (hard_p)
    );

    assign xfer    = mem_req && mem_gnt;
    assign ins_ent = '{addr: cur, prio: mem_rdata[31:24], intr: mem_rdata[23]};
    assign q_ins   = (state == S_RD_CW1) && xfer;
    assign q_pop   = (state == S_SCHED) && (state_n == S_EXEC);
    assign q_flush = hard_p || ((state != S_IDLE) && (state_n == S_IDLE));

    dq_prio_queue #(.DEPTH(QDEPTH)) u_q (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (q_flush),
        .ins    (q_ins),
        .ins_ent(ins_ent),
        .pop    (q_pop),
        .head   (q_head),
        .full   (q_full),
        .empty  (q_empty)
    );

    dq_lat_timer #(.LAT_W(LAT_W)) u_t (
        .clk  (clk),
        .rst_n(rst_n),
        .load (q_pop),
        .lat  (cmd_lat),
        .run  (state == S_EXEC),
        .done (t_done)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (start_p)      state_n = S_RD_CTL;
                else if (id_pend) state_n = S_ID_WR;
            end
            S_RD_CTL: if (xfer) begin
                if (stop_pend)    state_n = S_IDLE;
                else if (mem_rdata[CTL_QUEUED] || mem_rdata[CTL_IMMED])
                                  state_n = S_CLR_STS;
                else              state_n = S_IDLE;
            end
            S_CLR_STS: if (xfer) state_n = stop_pend ? S_IDLE : S_RD_HEAD;
            S_RD_HEAD: if (xfer) begin
                if (stop_pend || mem_rdata == '0) state_n = S_IDLE;
                else                              state_n = S_RD_LINK;
            end
            S_RD_LINK: if (xfer) state_n = stop_pend ? S_IDLE : S_RD_CW1;
            S_RD_CW1:  if (xfer) state_n = stop_pend ? S_IDLE : S_SCHED;
            S_SCHED: begin
                if (stop_pend)                          state_n = S_IDLE;
                else if (id_pend)                       state_n = S_ID_WR;
                else if (!imm && cur != '0 && !q_full)  state_n = S_RD_LINK;
                else if (!q_empty)                      state_n = S_EXEC;
                else if (!imm && tail != '0)            state_n = S_RECHECK;
                else                                    state_n = S_IDLE;
            end
            S_RECHECK: if (xfer) begin
                if (stop_pend || mem_rdata == '0) state_n = S_IDLE;
                else                              state_n = S_SCHED;
            end
            S_EXEC: begin
                if (stop_pend)   state_n = S_IDLE;
                else if (t_done) state_n = S_RD_CTX;
            end
            S_RD_CTX:   if (xfer) state_n = stop_pend ? S_IDLE : S_WB_CTX;
            S_WB_CTX:   if (xfer) state_n = stop_pend ? S_IDLE : S_WB_CADDR;
            S_WB_CADDR: if (xfer) state_n = stop_pend ? S_IDLE : S_WB_STS;
            S_WB_STS:   if (xfer) state_n = stop_pend ? S_IDLE : S_SCHED;
            S_ID_WR: if (xfer) begin
                if (stop_pend)   state_n = S_IDLE;
                else             state_n = id_ret ? S_SCHED : S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= S_IDLE;
        else if (hard_p) state <= S_IDLE;
        else             state <= state_n;
    end

    // memory port outputs
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_RD_CTL:   mem_addr = mb + MB_CTL;
            S_CLR_STS:  begin mem_we = 1'b1; mem_addr = mb + MB_STS; end
            S_RD_HEAD:  mem_addr = mb + MB_HEAD;
            S_RD_LINK:  mem_addr = cur + DS_NEXT;
            S_RD_CW1:   mem_addr = cur + DS_CW1;
            S_RECHECK:  mem_addr = tail + DS_NEXT;
            S_RD_CTX:   mem_addr = exec_ent.addr + DS_CTX;
            S_WB_CTX:   begin mem_we = 1'b1; mem_addr = mb + MB_CTX; mem_wdata = ctx; end
            S_WB_CADDR: begin mem_we = 1'b1; mem_addr = mb + MB_CADDR; mem_wdata = exec_ent.addr; end
            S_WB_STS:   begin
                mem_we    = 1'b1;
                mem_addr  = mb + MB_STS;
                mem_wdata = {24'd0, 1'b1, 5'd0, err_q};
            end
            S_ID_WR:    begin mem_we = 1'b1; mem_addr = id_addr; mem_wdata = ID_WORD; end
            default:    mem_req = 1'b0;
        endcase
    end

    assign irq = irq_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb <= '0; cur <= '0; nxt <= '0; tail <= '0; id_addr <= '0;
            ctx <= '0; err_q <= '0; imm <= 1'b0; id_pend <= 1'b0;
            id_ret <= 1'b0; stop_pend <= 1'b0; irq_q <= 1'b0;
            exec_ent <= '0;
        end else if (hard_p) begin
            id_pend   <= 1'b0;
            stop_pend <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (state == S_IDLE && start_p) begin
                mb   <= reg_wdata;
                cur  <= '0;
                tail <= '0;
            end
            if (id_p) begin
                id_pend <= 1'b1;
                id_addr <= reg_wdata;
            end else if (state == S_ID_WR && xfer) begin
                id_pend <= 1'b0;
            end
            if (state_n == S_ID_WR && state != S_ID_WR)
                id_ret <= (state == S_SCHED);
            if (soft_p && state != S_IDLE) stop_pend <= 1'b1;
            else if (state == S_IDLE)      stop_pend <= 1'b0;
            if (xfer) begin
                unique case (state)
                    S_RD_CTL:  imm <= !mem_rdata[CTL_QUEUED] && mem_rdata[CTL_IMMED];
                    S_RD_HEAD: cur <= mem_rdata;
                    S_RD_LINK: nxt <= mem_rdata;
                    S_RD_CW1:  begin tail <= cur; cur <= nxt; end
                    S_RECHECK: cur <= mem_rdata;
                    S_RD_CTX:  ctx <= mem_rdata;
                    S_WB_STS:  irq_q <= exec_ent.intr;
                    default: ;
                endcase
            end
            if (q_pop) exec_ent <= q_head;
            if (state == S_EXEC && t_done) err_q <= cmd_err;
        end
    end

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !hard_p) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    a_r13_hard_drop: assert property (@(posedge clk) disable iff (!rst_n)
        hard_p |=> !mem_req);
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r8_irq_after_sts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_gnt && mem_we && mem_addr == mb + MB_STS));
    a_r12_stop_no_sched: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend && state == S_SCHED && !hard_p) |=> (state == S_IDLE));
endmodule

// File: tb/sim_desc_queue_ctrl.sv
`timescale 1ns/1ps
module sim_desc_queue_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] cmd_lat = 16'd3;
    logic [1:0]  cmd_err = 2'b00;
    logic        irq;

    always #2.5 clk = ~clk;

    desc_queue_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .cmd_lat(cmd_lat), .cmd_err(cmd_err), .irq(irq)
    );

    logic [31:0] mem [0:1023];
    logic [31:0] done_addr [0:255];
    logic [31:0] done_ctx  [0:255];
    logic [31:0] done_sts  [0:255];
    logic        irq_seen  [0:255];
    int          n_done = 0;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    int          wcnt = 0;
    int          gnt_wait = 0;
    bit          gnt_hold = 1'b0;
    bit          irq_prev = 1'b0;
    logic [31:0] mb_base = '0;
    logic [31:0] last_caddr = '0;
    logic [31:0] last_ctx = '0;

    function automatic int widx(input logic [31:0] a);
        return int'(a[11:2]);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
        end
    endtask

    task automatic mem_step();
        cyc++;
        if (mem_req && !gnt_hold && wcnt >= gnt_wait) begin
            mem_gnt   = 1'b1;
            mem_rdata = mem[widx(mem_addr)];
            if (mem_we) begin
                mem[widx(mem_addr)] = mem_wdata;
                if (mem_addr == mb_base + 32'd24) last_caddr = mem_wdata;
                if (mem_addr == mb_base + 32'd28) last_ctx = mem_wdata;
                if (mem_addr == mb_base + 32'd20 && mem_wdata[7]) begin
                    done_addr[n_done & 255] = last_caddr;
                    done_ctx[n_done & 255]  = last_ctx;
                    done_sts[n_done & 255]  = mem_wdata;
                    irq_seen[n_done & 255]  = 1'b0;
                    n_done++;
                end
            end
            wcnt = 0;
        end else begin
            mem_gnt = 1'b0;
            if (mem_req) wcnt++;
        end
        if (irq) begin
            if (irq_prev) chk(1'b0, "R8 irq longer than one cycle", 32'd1, 32'd0);
            if (n_done > 0) irq_seen[(n_done - 1) & 255] = 1'b1;
        end
        irq_prev = irq;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic mk_desc(input logic [31:0] a, input logic [31:0] nx,
                           input logic [7:0] prio, input bit intr,
                           input logic [31:0] cx);
        mem[widx(a)]     = nx;
        mem[widx(a) + 1] = {prio, intr, 7'd2, 16'h0060};
        mem[widx(a) + 2] = 32'h0;
        mem[widx(a) + 5] = cx;
    endtask

    task automatic setup_mb(input logic [31:0] a, input logic [31:0] ctl,
                            input logic [31:0] hd);
        mem[widx(a)]     = ctl;
        mem[widx(a) + 2] = hd;
        mem[widx(a) + 5] = 32'hDEAD_BEEF;
        mem[widx(a) + 6] = 32'h0;
        mem[widx(a) + 7] = 32'h0;
        mb_base = a;
    endtask

    task automatic wait_done(input int base, input int n, input int limit);
        int k = 0;
        while ((n_done - base) < n && k < limit) begin
            @(negedge clk);
            k++;
        end
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 32'd0);
        chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'd0);
    endtask

    task automatic t_identity();
        mem[widx(32'h3F0)] = 32'h0;
        reg_write(2'd1, 32'h3F0);
        repeat (10) @(negedge clk);
        chk(mem[widx(32'h3F0)] == 32'hFF12_0001, "R11 identity word",
            mem[widx(32'h3F0)], 32'hFF12_0001);
    endtask

    task automatic t_handover();
        int base = n_done;
        setup_mb(32'h100, 32'h0, 32'h0);
        reg_write(2'd0, 32'h100);
        repeat (20) @(negedge clk);
        chk(mem[widx(32'h114)] == 32'hDEAD_BEEF, "R2 no mode leaves status",
            mem[widx(32'h114)], 32'hDEAD_BEEF);
        setup_mb(32'h100, 32'h1, 32'h0);
        reg_write(2'd0, 32'h100);
        repeat (20) @(negedge clk);
        chk(mem[widx(32'h114)] == 32'h0, "R2 status cleared on handover",
            mem[widx(32'h114)], 32'h0);
        chk(n_done == base && !mem_req, "R4 zero head ends chain",
            32'(n_done - base), 32'd0);
    endtask

    task automatic t_queued();
        int base = n_done;
        gnt_wait = 1;
        setup_mb(32'h100, 32'h10, 32'h200);
        mk_desc(32'h200, 32'h240, 8'd3, 1'b1, 32'hC000_0001);
        mk_desc(32'h240, 32'h280, 8'd7, 1'b0, 32'hC000_0002);
        mk_desc(32'h280, 32'h0,   8'd3, 1'b1, 32'hC000_0003);
        reg_write(2'd0, 32'h100);
        wait_done(base, 3, 2000);
        chk(n_done - base == 3, "R5 completion count", 32'(n_done - base), 32'd3);
        chk(done_addr[base] == 32'h240, "R5 highest priority first",
            done_addr[base], 32'h240);
        chk(done_addr[base+1] == 32'h200, "R5 equal priority fetch order",
            done_addr[base+1], 32'h200);
        chk(done_addr[base+2] == 32'h280, "R5 equal priority fetch order",
            done_addr[base+2], 32'h280);
        chk(done_ctx[base] == 32'hC000_0002, "R7 context copied",
            done_ctx[base], 32'hC000_0002);
        chk(done_sts[base] == 32'h80, "R7 done status", done_sts[base], 32'h80);
        chk(irq_seen[base] == 1'b0, "R8 no irq without bit", 32'(irq_seen[base]), 32'd0);
        chk(irq_seen[base+1] == 1'b1, "R8 irq with bit", 32'(irq_seen[base+1]), 32'd1);
        chk(irq_seen[base+2] == 1'b1, "R8 irq with bit", 32'(irq_seen[base+2]), 32'd1);
        gnt_wait = 0;
    endtask

    task automatic t_immediate();
        int base = n_done;
        setup_mb(32'h100, 32'h1, 32'h200);
        mk_desc(32'h200, 32'h240, 8'd1, 1'b0, 32'hA1);
        mk_desc(32'h240, 32'h0,   8'd9, 1'b0, 32'hA2);
        reg_write(2'd0, 32'h100);
        wait_done(base, 2, 300);
        chk(n_done - base == 1, "R6 immediate runs one", 32'(n_done - base), 32'd1);
        chk(done_addr[base] == 32'h200, "R6 immediate runs head",
            done_addr[base], 32'h200);
    endtask

    task automatic t_errors();
        int base = n_done;
        cmd_err = 2'b10;
        setup_mb(32'h100, 32'h10, 32'h200);
        mk_desc(32'h200, 32'h0, 8'd1, 1'b0, 32'hE1);
        reg_write(2'd0, 32'h100);
        wait_done(base, 1, 500);
        chk(done_sts[base] == 32'h82, "R7 fatal error bit", done_sts[base], 32'h82);
        cmd_err = 2'b01;
        setup_mb(32'h100, 32'h10, 32'h200);
        reg_write(2'd0, 32'h100);
        wait_done(base + 1, 1, 500);
        chk(done_sts[base+1] == 32'h81, "R7 recoverable error bit",
            done_sts[base+1], 32'h81);
        cmd_err = 2'b00;
    endtask

    task automatic t_capacity();
        int base = n_done;
        bit order_ok = 1'b1;
        cmd_lat = 16'd1;
        setup_mb(32'h100, 32'h10, 32'h400);
        for (int i = 0; i < 33; i++) begin
            mk_desc(32'h400 + 32'(i) * 32'h20,
                    (i == 32) ? 32'h0 : 32'h400 + 32'(i + 1) * 32'h20,
                    (i == 32) ? 8'd9 : 8'd1, 1'b0, 32'(i));
        end
        reg_write(2'd0, 32'h100);
        wait_done(base, 33, 5000);
        chk(n_done - base == 33, "R9 all completed", 32'(n_done - base), 32'd33);
        chk(done_addr[base] == 32'h400, "R9 first queued runs first",
            done_addr[base], 32'h400);
        chk(done_addr[base+1] == 32'h800, "R9 33rd waits for a free slot",
            done_addr[base+1], 32'h800);
        for (int i = 2; i < 33; i++)
            if (done_addr[base+i] != 32'h400 + 32'(i - 1) * 32'h20) order_ok = 1'b0;
        chk(order_ok, "R9 remaining order", 32'(order_ok), 32'd1);
        cmd_lat = 16'd3;
    endtask

    task automatic t_append();
        int base = n_done;
        cmd_lat = 16'd40;
        setup_mb(32'h100, 32'h10, 32'h200);
        mk_desc(32'h200, 32'h0, 8'd2, 1'b0, 32'hB1);
        mk_desc(32'h240, 32'h0, 8'd2, 1'b0, 32'hB2);
        reg_write(2'd0, 32'h100);
        repeat (20) @(negedge clk);
        mem[widx(32'h200)] = 32'h240;
        wait_done(base, 2, 1000);
        chk(n_done - base == 2, "R10 appended runs", 32'(n_done - base), 32'd2);
        chk(done_addr[base+1] == 32'h240, "R10 appended address",
            done_addr[base+1], 32'h240);
        cmd_lat = 16'd3;
    endtask

    task automatic t_busy_start();
        int base = n_done;
        cmd_lat = 16'd60;
        mem[widx(32'h194)] = 32'h5555_AAAA;
        setup_mb(32'h100, 32'h10, 32'h200);
        mk_desc(32'h200, 32'h0, 8'd2, 1'b0, 32'hD1);
        reg_write(2'd0, 32'h100);
        repeat (20) @(negedge clk);
        reg_write(2'd0, 32'h180);
        wait_done(base, 1, 1000);
        chk(mem[widx(32'h194)] == 32'h5555_AAAA, "R14 busy start ignored",
            mem[widx(32'h194)], 32'h5555_AAAA);
        chk(n_done - base == 1, "R14 first run completes", 32'(n_done - base), 32'd1);
        cmd_lat = 16'd3;
    endtask

    task automatic t_soft();
        int base = n_done;
        gnt_hold = 1'b1;
        setup_mb(32'h100, 32'h10, 32'h200);
        mk_desc(32'h200, 32'h0, 8'd2, 1'b0, 32'hF1);
        reg_write(2'd0, 32'h100);
        repeat (3) @(negedge clk);
        reg_write(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        chk(mem_req == 1'b1, "R12 transfer still held", 32'(mem_req), 32'd1);
        gnt_hold = 1'b0;
        repeat (10) @(negedge clk);
        chk(mem_req == 1'b0, "R12 idle after transfer", 32'(mem_req), 32'd0);
        chk(mem[widx(32'h114)] == 32'hDEAD_BEEF, "R12 no further transfer",
            mem[widx(32'h114)], 32'hDEAD_BEEF);
        cmd_lat = 16'd100;
        setup_mb(32'h100, 32'h10, 32'h200);
        reg_write(2'd0, 32'h100);
        repeat (20) @(negedge clk);
        reg_write(2'd2, 32'h0);
        repeat (150) @(negedge clk);
        chk(n_done == base, "R12 stop during execution", 32'(n_done - base), 32'd0);
        chk(mem_req == 1'b0, "R12 idle after stop", 32'(mem_req), 32'd0);
        cmd_lat = 16'd3;
    endtask

    task automatic t_hard();
        int base = n_done;
        gnt_hold = 1'b1;
        setup_mb(32'h100, 32'h10, 32'h200);
        mk_desc(32'h200, 32'h0, 8'd2, 1'b1, 32'h71);
        reg_write(2'd0, 32'h100);
        repeat (3) @(negedge clk);
        reg_write(2'd3, 32'h0);
        chk(mem_req == 1'b0, "R13 request dropped", 32'(mem_req), 32'd0);
        gnt_hold = 1'b0;
        repeat (5) @(negedge clk);
        chk(mem_req == 1'b0, "R13 stays idle", 32'(mem_req), 32'd0);
        reg_write(2'd0, 32'h100);
        wait_done(base, 1, 500);
        chk(done_addr[base] == 32'h200, "R13 restart after hard stop",
            done_addr[base], 32'h200);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        fork
            forever begin
                @(negedge clk);
                mem_step();
                if (cyc > 150000) begin
                    chk(1'b0, "watchdog expired", 32'(cyc), 32'd150000);
                    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                    $finish;
                end
            end
        join_none
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_identity();
        t_handover();
        t_queued();
        t_immediate();
        t_errors();
        t_capacity();
        t_append();
        t_busy_start();
        t_soft();
        t_hard();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule